// File: doc/BRIEF.md
# Module Stop Clock Gating Controller

This block holds the per-module clock stop bits for a set of peripheral modules and drives one clock-enable line per module. Software reaches it over a simple word-addressed register bus. Each control word carries the stop bits of 32 modules, and the block accepts a full-word write so that a read-modify-write sequence can change any subset of those bits in one cycle. A stop bit of 1 holds the module's clock off, and a 0 lets it run.

Next to every control word sits a read-only status word. A status bit shows whether the gate has actually taken effect. The block models the settling time of a real gate with a fixed acknowledge latency. A status bit, and with it the module's clock-enable output, copies its control bit a parameterised number of cycles after the write. Software that turns a module on polls the status bit until it reads 0. Software that turns a module off does not wait. After reset every module is stopped except the modules named in a critical-module mask, which come out of reset running.

Top module: `modstop_gate_ctrl`

## Requirements
- R1: A control bit of 1 stops the clock of its module and a 0 lets it run. The module's clock-enable output is 1 exactly while its status bit reads 0.
- R2: Module n is controlled by bit n%32 of control word n/32, which sits at word address n/32. Its status is bit n%32 of the status word at word address STAT_BASE + n/32.
- R3: A write to a control word replaces all of its implemented bits at once. A read of that word in the cycle after the write returns the new value.
- R4: A status bit, and the matching clock-enable output, takes the new control value exactly ACK_DELAY clock edges after the edge that accepted the write, and not before.
- R5: Starting a module and stopping it both settle within the same bound of ACK_DELAY cycles. A status bit of 0 confirms that the module is running.
- R6: After reset every control and status bit is 1 (stopped), except the bits set in CRIT_MASK, which are 0 (running).
- R7: A read from an address that is neither a control word nor a status word returns 0. A write to such an address changes no control bit and no clock-enable output.
- R8: Bit positions at or above NUM_MODULES in the last word read as 0 in both the control and the status view. Writes to those positions have no effect.
- R9: Status words are read-only. A write to a status address changes no control bit and no clock-enable output.
- R10: A write to one control word leaves every other control word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Word address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| mod_clk_en_o | output | NUM_MODULES | Per-module clock enable, 1 = clock running |

## Verification
The hardest behaviour to reach from the ports is the exact edge on which an acknowledge lands. The status bit and the clock-enable output must hold their old value for ACK_DELAY-1 edges and then change on exactly the next edge. The bench therefore writes a control word with a single bit flipped and inspects the status word and the enable line after every edge in that window, once for a start and once for a stop. It also writes whole words with mixed bit patterns into the short last word, so that the unimplemented upper positions and the word-select arithmetic are tested against independently computed masks.

// File: rtl/modstop_pkg.sv
package modstop_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2
  } modstop_sel_e;

  function automatic int unsigned words_for(input int unsigned n);
    return (n + WORD_W - 1) / WORD_W;
  endfunction

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/modstop_bus_decode.sv
module modstop_bus_decode
  import modstop_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned NREG      = 3,
  parameter int unsigned STAT_BASE = 16,
  localparam int unsigned IDX_W    = idx_bits(NREG)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output modstop_sel_e      sel_o,
  output logic [IDX_W-1:0]  idx_o
);

  localparam logic [ADDR_W-1:0] CTRL_END  = ADDR_W'(NREG);
  localparam logic [ADDR_W-1:0] STAT_LO   = ADDR_W'(STAT_BASE);
  localparam logic [ADDR_W-1:0] STAT_END  = ADDR_W'(STAT_BASE + NREG);

  logic [ADDR_W-1:0] stat_off;

  assign stat_off = addr_i - STAT_LO;

  always_comb begin
    sel_o = SEL_NONE;
    idx_o = '0;
    if (addr_i < CTRL_END) begin
      sel_o = SEL_CTRL;
      idx_o = IDX_W'(addr_i);
    end else if ((addr_i >= STAT_LO) && (addr_i < STAT_END)) begin
      sel_o = SEL_STAT;
      idx_o = IDX_W'(stat_off);
    end
  end

endmodule

// File: rtl/modstop_ctrl_regs.sv
module modstop_ctrl_regs
  import modstop_pkg::*;
#(
  parameter int unsigned NUM_MODULES          = 80,
  parameter logic [NUM_MODULES-1:0] RST_VAL   = '1,
  localparam int unsigned NREG                = words_for(NUM_MODULES),
  localparam int unsigned IDX_W               = idx_bits(NREG)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [WORD_W-1:0]      wdata_i,
  output logic [NUM_MODULES-1:0] ctrl_o
);

  for (genvar k = 0; k < NREG; k++) begin : g_word
    localparam int unsigned LO = k * WORD_W;
    localparam int unsigned W  = ((NUM_MODULES - LO) < WORD_W) ? (NUM_MODULES - LO) : WORD_W;

    logic         word_en;
    logic [W-1:0] word_d;
    logic [W-1:0] word_q;

    // next state: whole-word replace of the implemented bits
    always_comb begin
      word_en = wr_en_i && (wr_idx_i == IDX_W'(k));
      word_d  = wdata_i[W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q <= RST_VAL[LO +: W];
      end else if (word_en) begin
        word_q <= word_d;
      end
    end

    assign ctrl_o[LO +: W] = word_q;
  end

endmodule

// File: rtl/modstop_ack_pipe.sv
module modstop_ack_pipe #(
  parameter int unsigned WIDTH              = 80,
  parameter int unsigned DEPTH              = 4,
  parameter logic [WIDTH-1:0] RST_VAL       = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_st
    logic [WIDTH-1:0] din;
    logic [WIDTH-1:0] q;

    if (i == 0) begin : g_head
      assign din = d_i;
    end else begin : g_link
      assign din = g_st[i-1].q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= RST_VAL;
      end else begin
        q <= din;
      end
    end
  end

  assign q_o = g_st[DEPTH-1].q;

endmodule

// File: rtl/modstop_gate_ctrl.sv
module modstop_gate_ctrl
  import modstop_pkg::*;
#(
  parameter int unsigned NUM_MODULES          = 80,
  parameter int unsigned ACK_DELAY            = 4,
  parameter int unsigned ADDR_W               = 6,
  parameter int unsigned STAT_BASE            = 16,
  parameter logic [NUM_MODULES-1:0] CRIT_MASK = NUM_MODULES'(1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      bus_addr_i,
  input  logic [31:0]            bus_wdata_i,
  input  logic                   bus_we_i,
  output logic [31:0]            bus_rdata_o,
  output logic [NUM_MODULES-1:0] mod_clk_en_o
);

  localparam int unsigned NREG  = words_for(NUM_MODULES);
  localparam int unsigned IDX_W = idx_bits(NREG);
  localparam int unsigned PAD_W = NREG * WORD_W;
  localparam logic [NUM_MODULES-1:0] STOP_RST = ~CRIT_MASK;

  modstop_sel_e           sel;
  logic [IDX_W-1:0]       idx;
  logic                   ctrl_wr;
  logic [NUM_MODULES-1:0] ctrl_q;
  logic [NUM_MODULES-1:0] stat_q;
  logic [PAD_W-1:0]       ctrl_pad;
  logic [PAD_W-1:0]       stat_pad;

  modstop_bus_decode #(
    .ADDR_W   (ADDR_W),
    .NREG     (NREG),
    .STAT_BASE(STAT_BASE)
  ) u_decode (
    .addr_i(bus_addr_i),
    .sel_o (sel),
    .idx_o (idx)
  );

  assign ctrl_wr = bus_we_i && (sel == SEL_CTRL);

  modstop_ctrl_regs #(
    .NUM_MODULES(NUM_MODULES),
    .RST_VAL    (STOP_RST)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (ctrl_wr),
    .wr_idx_i(idx),
    .wdata_i (bus_wdata_i),
    .ctrl_o  (ctrl_q)
  );

  modstop_ack_pipe #(
    .WIDTH  (NUM_MODULES),
    .DEPTH  (ACK_DELAY),
    .RST_VAL(STOP_RST)
  ) u_ack (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctrl_q),
    .q_o   (stat_q)
  );

  // the gate is open only once the acknowledge reports running
  assign mod_clk_en_o = ~stat_q;

  always_comb begin
    ctrl_pad                  = '0;
    stat_pad                  = '0;
    ctrl_pad[NUM_MODULES-1:0] = ctrl_q;
    stat_pad[NUM_MODULES-1:0] = stat_q;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: bus_rdata_o = ctrl_pad[idx*WORD_W +: WORD_W];
      SEL_STAT: bus_rdata_o = stat_pad[idx*WORD_W +: WORD_W];
      default:  bus_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/modstop_gate_chk.sv
module modstop_gate_chk #(
  parameter int unsigned NUM_MODULES = 80,
  parameter int unsigned ACK_DELAY   = 4,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned STAT_BASE   = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [ADDR_W-1:0]      bus_addr_i,
  input logic                   bus_we_i,
  input logic [31:0]            bus_rdata_o,
  input logic [NUM_MODULES-1:0] mod_clk_en_o,
  input logic [NUM_MODULES-1:0] ctrl_q,
  input logic [NUM_MODULES-1:0] stat_q
);

  localparam int unsigned NREG  = (NUM_MODULES + 31) / 32;
  localparam int unsigned REM   = NUM_MODULES % 32;
  localparam int unsigned CNT_W = $clog2(ACK_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ACK_DELAY);

  logic [NUM_MODULES-1:0] prev_ctrl;
  logic [CNT_W-1:0]       quiet_cnt;
  logic                   settled;
  logic                   in_ctrl;
  logic                   in_stat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_ctrl <= '0;
      quiet_cnt <= '0;
    end else begin
      prev_ctrl <= ctrl_q;
      if (ctrl_q != prev_ctrl) begin
        quiet_cnt <= '0;
      end else if (quiet_cnt != CNT_MAX) begin
        quiet_cnt <= quiet_cnt + 1'b1;
      end
    end
  end

  assign settled = (quiet_cnt == CNT_MAX) && (ctrl_q == prev_ctrl);
  assign in_ctrl = (int'(bus_addr_i) < NREG);
  assign in_stat = (int'(bus_addr_i) >= STAT_BASE) && (int'(bus_addr_i) < STAT_BASE + NREG);

  // R4
  stat_follows_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled |-> (stat_q == ctrl_q));

  // R1
  enable_matches_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled |-> (mod_clk_en_o == ~ctrl_q));

  // R7
  unmapped_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_ctrl && !in_stat) |-> (bus_rdata_o == 32'd0));

  // R9
  status_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && in_stat) |=> $stable(ctrl_q));

  if (REM != 0) begin : g_tail
    localparam logic [31:0] HI_MASK = ~((32'd1 << REM) - 32'd1);
    logic last_word;
    assign last_word = (int'(bus_addr_i) == NREG - 1) || (int'(bus_addr_i) == STAT_BASE + NREG - 1);

    // R8
    tail_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      last_word |-> ((bus_rdata_o & HI_MASK) == 32'd0));
  end

endmodule

bind modstop_gate_ctrl modstop_gate_chk #(
  .NUM_MODULES(NUM_MODULES),
  .ACK_DELAY  (ACK_DELAY),
  .ADDR_W     (ADDR_W),
  .STAT_BASE  (STAT_BASE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_we_i    (bus_we_i),
  .bus_rdata_o (bus_rdata_o),
  .mod_clk_en_o(mod_clk_en_o),
  .ctrl_q      (ctrl_q),
  .stat_q      (stat_q)
);

// File: tb/modstop_gate_ctrl_bench.sv
module modstop_gate_ctrl_bench;

  localparam int unsigned NM   = 80;
  localparam int unsigned ACK  = 4;
  localparam int unsigned AW   = 6;
  localparam int unsigned SB   = 16;
  localparam logic [NM-1:0] CRIT = (NM'(1) << 0) | (NM'(1) << 33);

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic          we;
  logic [31:0]   rdata;
  logic [NM-1:0] clk_en;

  int n_checks;
  int n_fail;
  logic [31:0] exp_ctrl [3];

  modstop_gate_ctrl #(
    .NUM_MODULES(NM),
    .ACK_DELAY  (ACK),
    .ADDR_W     (AW),
    .STAT_BASE  (SB),
    .CRIT_MASK  (CRIT)
  ) u_modstop_gate_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_we_i    (we),
    .bus_rdata_o (rdata),
    .mod_clk_en_o(clk_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [NM-1:0] act, input logic [NM-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    addr = AW'(a);
    #1;
    v = rdata;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr  = AW'(a);
    wdata = d;
    we    = 1'b1;
    step();
    we    = 1'b0;
  endtask

  function automatic logic [NM-1:0] exp_en();
    return ~{exp_ctrl[2][15:0], exp_ctrl[1], exp_ctrl[0]};
  endfunction

  task automatic check_all(input string req);
    logic [31:0] v;
    for (int k = 0; k < 3; k++) begin
      rd(k, v);
      chk(v == exp_ctrl[k], req, NM'(v), NM'(exp_ctrl[k]));
      rd(SB + k, v);
      chk(v == exp_ctrl[k], req, NM'(v), NM'(exp_ctrl[k]));
    end
    chk(clk_en == exp_en(), req, clk_en, exp_en());
  endtask

  task automatic t_reset();
    exp_ctrl[0] = 32'hFFFF_FFFE;
    exp_ctrl[1] = 32'hFFFF_FFFD;
    exp_ctrl[2] = 32'h0000_FFFF;
    check_all("R6 reset state");
  endtask

  task automatic t_start_latency();
    logic [31:0] v;
    exp_ctrl[1] = 32'hFFFF_FEFD;
    wr(1, exp_ctrl[1]);
    rd(1, v);
    chk(v == exp_ctrl[1], "R3 readback next cycle", NM'(v), NM'(exp_ctrl[1]));
    for (int k = 1; k <= ACK; k++) begin
      step();
      rd(SB + 1, v);
      if (k < ACK) begin
        chk(v[8] == 1'b1 && clk_en[40] == 1'b0, "R4 start not early", NM'(v), NM'(32'hFFFF_FFFD));
      end else begin
        chk(v[8] == 1'b0, "R5 start confirmed at ACK_DELAY", NM'(v), NM'(exp_ctrl[1]));
        chk(clk_en[40] == 1'b1, "R1 R2 module 40 running", clk_en, exp_en());
      end
    end
  endtask

  task automatic t_stop_latency();
    exp_ctrl[1] = 32'hFFFF_FFFD;
    wr(1, exp_ctrl[1]);
    for (int k = 1; k <= ACK; k++) begin
      step();
      if (k < ACK)
        chk(clk_en[40] == 1'b1, "R4 stop not early", clk_en, ~exp_en());
      else
        chk(clk_en[40] == 1'b0, "R5 stop within ACK_DELAY", clk_en, exp_en());
    end
    check_all("R1 after stop");
  endtask

  task automatic t_full_word();
    exp_ctrl[0] = 32'h0000_0000;
    wr(0, exp_ctrl[0]);
    repeat (ACK - 1) step();
    chk(clk_en[31:0] == 32'h1, "R3 word not yet applied", clk_en, NM'(1));
    step();
    chk(clk_en[31:0] == 32'hFFFF_FFFF, "R3 all 32 bits together", clk_en, exp_en());
    exp_ctrl[0] = 32'hA5A5_5A5A;
    wr(0, exp_ctrl[0]);
    repeat (ACK + 1) step();
    check_all("R3 mixed pattern");
  endtask

  task automatic t_last_word();
    logic [31:0] v;
    exp_ctrl[2] = 32'h0000_0F0F;
    wr(2, 32'h1234_0F0F);
    repeat (ACK + 1) step();
    rd(2, v);
    chk(v == 32'h0000_0F0F, "R8 tail bits read zero", NM'(v), NM'(32'h0F0F));
    chk(clk_en[79:64] == 16'hF0F0, "R2 modules 64..79 map to word 2", clk_en, exp_en());
    check_all("R10 other words unchanged");
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(3, v);  chk(v == 0, "R7 read addr 3", NM'(v), '0);
    rd(15, v); chk(v == 0, "R7 read addr 15", NM'(v), '0);
    rd(19, v); chk(v == 0, "R7 read addr 19", NM'(v), '0);
    rd(63, v); chk(v == 0, "R7 read addr 63", NM'(v), '0);
    wr(3, 32'h0);
    wr(63, 32'h0);
    repeat (ACK + 2) step();
    check_all("R7 unmapped write ignored");
  endtask

  task automatic t_status_ro();
    wr(SB, 32'h0);
    wr(SB + 2, 32'hFFFF_FFFF);
    repeat (ACK + 2) step();
    check_all("R9 status write ignored");
  endtask

  initial begin
    #(200000 * 20);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    we       = 1'b0;
    addr     = '0;
    wdata    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start_latency();
    t_stop_latency();
    t_full_word();
    t_last_word();
    t_unmapped();
    t_status_ro();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule